// File: doc/BRIEF.md
# TDM Receive Frame Buffer

This block sits behind a TDM line serializer and collects one byte for each handled time slot into a 32-byte store. A frame is captured whole: the serializer marks the first byte of each frame. When the configured window of slot bytes has been captured, the block raises a frame-ready indication that doubles as an interrupt. The buffer then stays locked until software has drained exactly one window of bytes through the data register. Only after that last read is the buffer empty again, and it then waits for the next frame start.

Software uses a small register port. A status register reports frame-ready together with two sticky overflow flags. A data register pops the captured bytes in the order they arrived. A configuration register holds the two slot-window fields, which are also driven out to the serializer. A frame that starts while the buffer is still full is dropped as a unit and flagged. Bytes that the serializer delivers past the end of a window are dropped and flagged separately.

Top module: `rx_frame_buf`

## Requirements
- R1: After synchronous reset, `frame_irq` is 0, the status register reads 0, the configuration register reads 0, and `bus_rdata` is 0.
- R2: The window length is last - skip + 1 when last >= skip, and 1 otherwise. Last is configuration bits 4:0 and skip is bits 12:8. The length is latched when a frame-start byte is accepted. Ready rises at the clock edge that captures the window-th byte of that frame.
- R3: A read at offset 3 while ready returns the captured bytes in arrival order in `bus_rdata[7:0]`, with the upper bits 0. The value appears in the cycle after `bus_rd`. Ready falls at the edge of the window-th data read.
- R4: A data read while not ready returns 0x00 and does not change the buffer state.
- R5: A frame start that arrives while the buffer is full is dropped together with the rest of its bytes. It sets status bit 2, and the unread bytes already held are still returned intact.
- R6: A byte with no frame start that arrives while full, inside the frame that filled the buffer, is dropped and sets status bit 1.
- R7: A read at offset 2 returns ready in bit 0, line overflow in bit 1 and buffer overflow in bit 2, with all other bits 0. The read clears bits 1 and 2 unless a new overflow event occurs in the same cycle.
- R8: A write at offset 4 stores bits 4:0 as last and bits 12:8 as skip. A read at offset 4 returns them in the same places, with all other bits 0. Both fields also drive `win_last` and `win_skip`.
- R9: A frame start received while a frame is partly captured restarts capture at that byte. Bytes that arrive with no frame start while the buffer is empty are ignored.
- R10: `frame_irq` equals the ready status bit in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_vld | input | 1 | A slot byte is presented this cycle |
| slot_sof | input | 1 | The presented byte is the first of a frame |
| slot_byte | input | 8 | Slot byte from the serializer |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, held until the next read |
| frame_irq | output | 1 | Complete frame held |
| win_last | output | 5 | Configured last slot index |
| win_skip | output | 5 | Configured number of skipped slots |

## Verification
A wrong fill count or a wrong latched window length shows first on `frame_irq`. The bench compares that pin to its model on every clock, so the edge it rises on is checked exactly. A read pointer that slips or a corrupted store shows on the first data read after ready, in the cycle after the strobe. A drop state that is stuck or missing shows as a wrong status value on the next status read, and as stale or missing bytes on the frame after it. Windows of length 1, 2, 3 and 32 are driven, along with a skip value larger than last.

// File: rtl/rxfb_pkg.sv
package rxfb_pkg;

    localparam int CH_W   = 5;
    localparam int LEN_W  = CH_W + 1;
    localparam int DEPTH  = 2 ** CH_W;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;
    localparam int BUS_W  = 32;

    localparam logic [ADDR_W-1:0] OFS_STAT = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_DATA = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_CFG  = 3'd4;

    localparam int CFG_LAST_LSB = 0;
    localparam int CFG_SKIP_LSB = 8;

    typedef struct packed {
        logic [CH_W-1:0] skip;
        logic [CH_W-1:0] last;
    } win_cfg_t;

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_FILL = 2'd1,
        CAP_FULL = 2'd2
    } cap_state_e;

    typedef struct packed {
        logic line_ovf;
        logic buf_ovf;
    } ovf_evt_t;

    function automatic logic [LEN_W-1:0] window_len(win_cfg_t c);
        if (c.last >= c.skip)
            return LEN_W'(c.last) - LEN_W'(c.skip) + LEN_W'(1);
        else
            return LEN_W'(1);
    endfunction

endpackage

// File: rtl/rxfb_store.sv
module rxfb_store
    import rxfb_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [CH_W-1:0]   widx,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic [CH_W-1:0]   ridx,
    output logic [BYTE_W-1:0] rbyte
);

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[widx] <= wbyte;
    end

    assign rbyte = mem[ridx];

endmodule

// File: rtl/rxfb_capture.sv
module rxfb_capture
    import rxfb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            slot_vld,
    input  logic            slot_sof,
    input  win_cfg_t        cfg,
    input  logic            pop,
    output logic            mem_we,
    output logic [CH_W-1:0] mem_widx,
    output logic [CH_W-1:0] mem_ridx,
    output logic            ready,
    output ovf_evt_t        evt
);

    cap_state_e       state;
    logic [LEN_W-1:0] len;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] rptr;
    logic             dropping;
    logic [LEN_W-1:0] new_len;

    assign new_len = window_len(cfg);

    always_comb begin
        mem_we       = slot_vld && (state != CAP_FULL) && (slot_sof || state == CAP_FILL);
        mem_widx     = slot_sof ? '0 : cnt[CH_W-1:0];
        mem_ridx     = rptr[CH_W-1:0];
        ready        = (state == CAP_FULL);
        evt.buf_ovf  = slot_vld && (state == CAP_FULL) && slot_sof;
        evt.line_ovf = slot_vld && (state == CAP_FULL) && !slot_sof && !dropping;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= CAP_IDLE;
            len      <= LEN_W'(1);
            cnt      <= '0;
            rptr     <= '0;
            dropping <= 1'b0;
        end else begin
            case (state)
                CAP_IDLE, CAP_FILL: begin
                    if (slot_vld) begin
                        if (slot_sof) begin
                            len   <= new_len;
                            cnt   <= LEN_W'(1);
                            rptr  <= '0;
                            state <= (new_len == LEN_W'(1)) ? CAP_FULL : CAP_FILL;
                        end else if (state == CAP_FILL) begin
                            cnt <= cnt + LEN_W'(1);
                            if (cnt + LEN_W'(1) == len)
                                state <= CAP_FULL;
                        end
                    end
                end
                CAP_FULL: begin
                    if (slot_vld && slot_sof)
                        dropping <= 1'b1;
                    if (pop) begin
                        if (rptr + LEN_W'(1) == len) begin
                            state    <= CAP_IDLE;
                            rptr     <= '0;
                            dropping <= 1'b0;
                        end else begin
                            rptr <= rptr + LEN_W'(1);
                        end
                    end
                end
                default: state <= CAP_IDLE;
            endcase
        end
    end

    // R3: the buffer stays full until it is drained
    p_hold_ready_r3: assert property (@(posedge clk) disable iff (rst)
        ready && !pop |=> ready);

    // R3: the last pop of a window empties the buffer
    p_empty_after_window_r3: assert property (@(posedge clk) disable iff (rst)
        pop && (rptr + LEN_W'(1) == len) |=> !ready);

    // R5: held bytes are not disturbed while the buffer is full
    p_full_kept_r5: assert property (@(posedge clk) disable iff (rst)
        ready && !pop |=> $stable(mem_ridx) && $stable(len));

    // R2: a continuing byte is always written inside the window
    p_fill_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (state == CAP_FILL) && slot_vld && !slot_sof |-> cnt < len);

endmodule

// File: rtl/rxfb_regs.sv
module rxfb_regs
    import rxfb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              ready,
    input  logic [BYTE_W-1:0] rbyte,
    input  ovf_evt_t          evt,
    output logic              pop,
    output win_cfg_t          cfg
);

    logic line_sticky;
    logic buf_sticky;
    logic stat_rd;
    logic [BUS_W-1:0] rd_mux;

    assign stat_rd = bus_rd && (bus_addr == OFS_STAT);
    assign pop     = bus_rd && (bus_addr == OFS_DATA) && ready;

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            OFS_STAT: rd_mux[2:0] = {buf_sticky, line_sticky, ready};
            OFS_DATA: if (ready) rd_mux[BYTE_W-1:0] = rbyte;
            OFS_CFG: begin
                rd_mux[CFG_LAST_LSB +: CH_W] = cfg.last;
                rd_mux[CFG_SKIP_LSB +: CH_W] = cfg.skip;
            end
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata   <= '0;
            cfg         <= '0;
            line_sticky <= 1'b0;
            buf_sticky  <= 1'b0;
        end else begin
            if (bus_rd)
                bus_rdata <= rd_mux;
            if (bus_wr && bus_addr == OFS_CFG) begin
                cfg.last <= bus_wdata[CFG_LAST_LSB +: CH_W];
                cfg.skip <= bus_wdata[CFG_SKIP_LSB +: CH_W];
            end
            line_sticky <= evt.line_ovf | (line_sticky & ~stat_rd);
            buf_sticky  <= evt.buf_ovf  | (buf_sticky  & ~stat_rd);
        end
    end

    // R4: a data read without a held frame yields zero
    p_idle_read_zero_r4: assert property (@(posedge clk) disable iff (rst)
        bus_rd && (bus_addr == OFS_DATA) && !ready |=> bus_rdata == '0);

    // R7: a status read with no concurrent event clears both flags
    p_stat_clear_r7: assert property (@(posedge clk) disable iff (rst)
        stat_rd && !evt.line_ovf && !evt.buf_ovf |=> !line_sticky && !buf_sticky);

    // R7: an overflow event is always recorded
    p_evt_sets_r7: assert property (@(posedge clk) disable iff (rst)
        evt.buf_ovf |=> buf_sticky);

    // R8: reserved configuration bits never read back as ones
    p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (rst)
        $past(bus_rd) && $past(bus_addr) == OFS_CFG |-> bus_rdata[7:5] == 3'b0);

endmodule

// File: rtl/rx_frame_buf.sv
module rx_frame_buf
    import rxfb_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         slot_vld,
    input  logic         slot_sof,
    input  logic [7:0]   slot_byte,
    input  logic [2:0]   bus_addr,
    input  logic         bus_rd,
    input  logic         bus_wr,
    input  logic [31:0]  bus_wdata,
    output logic [31:0]  bus_rdata,
    output logic         frame_irq,
    output logic [4:0]   win_last,
    output logic [4:0]   win_skip
);

    win_cfg_t          cfg;
    ovf_evt_t          evt;
    logic              pop;
    logic              ready;
    logic              mem_we;
    logic [CH_W-1:0]   mem_widx;
    logic [CH_W-1:0]   mem_ridx;
    logic [BYTE_W-1:0] rbyte;

    rxfb_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .slot_vld (slot_vld),
        .slot_sof (slot_sof),
        .cfg      (cfg),
        .pop      (pop),
        .mem_we   (mem_we),
        .mem_widx (mem_widx),
        .mem_ridx (mem_ridx),
        .ready    (ready),
        .evt      (evt)
    );

    rxfb_store u_mem (
        .clk   (clk),
        .we    (mem_we),
        .widx  (mem_widx),
        .wbyte (slot_byte),
        .ridx  (mem_ridx),
        .rbyte (rbyte)
    );

    rxfb_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ready     (ready),
        .rbyte     (rbyte),
        .evt       (evt),
        .pop       (pop),
        .cfg       (cfg)
    );

    assign frame_irq = ready;
    assign win_last  = cfg.last;
    assign win_skip  = cfg.skip;

    // R10: the interrupt only rises after capture activity
    p_irq_rise_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_irq) |-> $past(slot_vld));

endmodule

// File: tb/sim_rx_frame_buf.sv
`timescale 1ns/1ps
module sim_rx_frame_buf;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slot_vld = 1'b0, slot_sof = 1'b0;
    logic [7:0]  slot_byte = 8'h00;
    logic [2:0]  bus_addr = 3'd0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        frame_irq;
    logic [4:0]  win_last, win_skip;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    rx_frame_buf u0 (
        .clk(clk), .rst(rst), .slot_vld(slot_vld), .slot_sof(slot_sof),
        .slot_byte(slot_byte), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .frame_irq(frame_irq), .win_last(win_last), .win_skip(win_skip)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit          m_full, m_fill, m_drop, m_line, m_buf;
    int          m_len, m_rdp, m_last, m_skip;
    logic [7:0]  m_q[$];
    logic [31:0] m_rdata;
    string       m_tag = "R1";

    always @(posedge clk) begin
        if (rst) begin
            m_full = 0; m_fill = 0; m_drop = 0; m_line = 0; m_buf = 0;
            m_len = 1; m_rdp = 0; m_last = 0; m_skip = 0;
            m_q.delete(); m_rdata = 0; m_tag = "R1";
        end else begin
            automatic bit pre_full = m_full;
            automatic bit do_pop = 0;
            automatic int wl = (m_last >= m_skip) ? m_last - m_skip + 1 : 1;
            if (bus_rd) begin
                case (bus_addr)
                    3'd2: begin
                        m_rdata = {29'b0, m_buf, m_line, m_full};
                        m_line = 0; m_buf = 0; m_tag = "R7";
                    end
                    3'd3: begin
                        if (m_full) begin
                            m_rdata = {24'b0, m_q[m_rdp]}; do_pop = 1; m_tag = "R3";
                        end else begin
                            m_rdata = 0; m_tag = "R4";
                        end
                    end
                    3'd4: begin
                        m_rdata = 0;
                        m_rdata[4:0] = 5'(m_last);
                        m_rdata[12:8] = 5'(m_skip);
                        m_tag = "R8";
                    end
                    default: begin m_rdata = 0; m_tag = "R8"; end
                endcase
            end
            if (slot_vld) begin
                if (pre_full) begin
                    if (slot_sof) begin m_buf = 1; m_drop = 1; end
                    else if (!m_drop) m_line = 1;
                end else if (slot_sof) begin
                    m_len = wl; m_q.delete(); m_q.push_back(slot_byte); m_rdp = 0;
                    if (m_len == 1) begin m_full = 1; m_fill = 0; end
                    else m_fill = 1;
                end else if (m_fill) begin
                    m_q.push_back(slot_byte);
                    if (m_q.size() == m_len) begin m_full = 1; m_fill = 0; end
                end
            end
            if (do_pop) begin
                m_rdp++;
                if (m_rdp == m_len) begin m_full = 0; m_drop = 0; m_rdp = 0; end
            end
            if (bus_wr && bus_addr == 3'd4) begin
                m_last = int'(bus_wdata[4:0]);
                m_skip = int'(bus_wdata[12:8]);
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check("R10", {31'b0, frame_irq}, {31'b0, m_full});
            check(m_tag, bus_rdata, m_rdata);
        end
    end

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic put(input logic [7:0] b, input logic sof);
        @(negedge clk); slot_vld = 1'b1; slot_sof = sof; slot_byte = b;
        @(negedge clk); slot_vld = 1'b0; slot_sof = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", {31'b0, frame_irq}, 32'h0);
        check("R1", bus_rdata, 32'h0);
        rd(3'd2, d); check("R1", d, 32'h0);
        rd(3'd4, d); check("R1", d, 32'h0);
        // R8 configuration: last=4 skip=3 -> window 2
        wr(3'd4, 32'hFFFF_E304);
        rd(3'd4, d); check("R8", d, 32'h0000_0304);
        check("R8", {27'b0, win_last}, 32'd4);
        check("R8", {27'b0, win_skip}, 32'd3);
        // R4 read before ready, R9 stray byte ignored
        rd(3'd3, d); check("R4", d, 32'h0);
        put(8'h11, 1'b0);
        check("R9", {31'b0, frame_irq}, 32'h0);
        // R2 frame of two
        put(8'hA1, 1'b1);
        check("R2", {31'b0, frame_irq}, 32'h0);
        put(8'hA2, 1'b0);
        check("R2", {31'b0, frame_irq}, 32'h1);
        rd(3'd2, d); check("R7", d, 32'h1);
        // R6 extra byte beyond the window
        put(8'h55, 1'b0);
        rd(3'd2, d); check("R6", d, 32'h3);
        rd(3'd2, d); check("R7", d, 32'h1);
        // R5 frame arriving while full
        put(8'hB1, 1'b1);
        put(8'hB2, 1'b0);
        rd(3'd2, d); check("R5", d, 32'h5);
        rd(3'd3, d); check("R5", d, 32'h0000_00A1);
        check("R3", {31'b0, frame_irq}, 32'h1);
        rd(3'd3, d); check("R3", d, 32'h0000_00A2);
        check("R3", {31'b0, frame_irq}, 32'h0);
        rd(3'd3, d); check("R4", d, 32'h0);
        put(8'hB3, 1'b0);
        check("R9", {31'b0, frame_irq}, 32'h0);
        // R9 restart: window 3
        wr(3'd4, 32'h0000_0002);
        put(8'hC1, 1'b1);
        put(8'hC2, 1'b0);
        put(8'hD1, 1'b1);
        put(8'hD2, 1'b0);
        check("R9", {31'b0, frame_irq}, 32'h0);
        put(8'hD3, 1'b0);
        rd(3'd3, d); check("R9", d, 32'h0000_00D1);
        rd(3'd3, d); check("R9", d, 32'h0000_00D2);
        rd(3'd3, d); check("R9", d, 32'h0000_00D3);
        // R2 skip greater than last -> window 1
        wr(3'd4, 32'h0000_0501);
        put(8'h77, 1'b1);
        check("R2", {31'b0, frame_irq}, 32'h1);
        rd(3'd3, d); check("R2", d, 32'h0000_0077);
        check("R2", {31'b0, frame_irq}, 32'h0);
        // R2/R3 full 32-byte window
        wr(3'd4, 32'h0000_001F);
        for (int i = 0; i < 32; i++) put(8'(8'h40 + i), i == 0);
        check("R2", {31'b0, frame_irq}, 32'h1);
        for (int i = 0; i < 32; i++) begin
            rd(3'd3, d); check("R3", d, 32'(8'h40 + i));
        end
        check("R3", {31'b0, frame_irq}, 32'h0);
        rd(3'd2, d); check("R7", d, 32'h0);
        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule